// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block keeps the status byte of a serial (SPI) memory and rules on every write request the instruction decoder passes to it. The decoder hands over single-cycle strobes: set the write-enable latch, clear it, load the status byte (with its data), and write the array (with the target address). The block answers a load or an array write in the same cycle with a grant or a reject. A granted request starts a short internal write cycle, during which the ready bit reads busy.

A granted write needs three conditions. The write-enable latch must be set. An array write must fall outside the block-protect region, which is counted down from the top of the array. A status load must not meet the hardware lock, which is active only when the active-low protect pin is low and the lock-enable bit in the status byte is set. The block-protect and lock-enable bits stand for non-volatile cells. They keep their value through reset and take a parameterised value at power-on. One parameter selects a 16 KiB or a 32 KiB array. A second parameter sets the length of the write cycle.

Top module: `statusWriteGuard`

## Requirements
- R1: The status byte reads bit 7 = lock-enable, bits 6..4 = 0, bits 3..2 = protect code (bit 3 high), bit 1 = write-enable latch, bit 0 = ready flag (1 = busy). Bits 6..4, 1 and 0 of loaded data have no effect.
- R2: The set strobe sets the write-enable latch and the clear strobe clears it, each seen in the status byte after the next clock edge. Reset clears the latch.
- R3: With the latch at 0, a status load or array write is answered with its reject output high and its grant output low in the strobe cycle. It changes no status bit.
- R4: Protect code 00 protects nothing. 01 protects the top quarter of the array, 10 the top half, and 11 the whole array. An array write into the protected range is rejected even with the latch at 1.
- R5: While the pin is low and lock-enable is 1, a status load is rejected. An array write outside the protected range is still granted when the latch is 1.
- R6: When the pin is high or lock-enable is 0, a status load with the latch at 1 is granted. After the edge, lock-enable equals data bit 7 and the protect code equals data bits 3..2.
- R7: After a granted write, the latch reads 0 and the ready flag reads 1 for exactly WRITE_CYCLES cycles, starting with the cycle after the grant.
- R8: While the ready flag is 1, whether from the internal timer or from the cycleBusy input, every strobe is ignored: no grant, no reject, no status change.
- R9: Reset leaves lock-enable and the protect code unchanged. At power-on they hold INIT_WPEN and INIT_BP.
- R10: When strobes coincide, only the highest one acts. The order is array write, then status load, then clear, then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEnStb | input | 1 | Set write-enable latch request |
| wrDisStb | input | 1 | Clear write-enable latch request |
| statWrStb | input | 1 | Status byte load request |
| statWrData | input | 8 | Data for the status load |
| arrWrStb | input | 1 | Array write request |
| arrWrAddr | input | ADDR_W | Target byte address of the array write |
| wpN | input | 1 | Write-protect pin, active low |
| cycleBusy | input | 1 | External write cycle in progress |
| statusByte | output | 8 | Status byte for a status read |
| statGrant | output | 1 | Status load accepted |
| statReject | output | 1 | Status load refused |
| arrGrant | output | 1 | Array write accepted |
| arrReject | output | 1 | Array write refused |

## Verification
The bench drives two instances with the same stimulus. One is a 32 KiB array whose power-on state is lock-enable 1 and protect code 10. The other is a 16 KiB array that powers on unprotected. The 32 KiB instance makes the reset-preserving behaviour visible from the first check. The shared addresses land on both sides of the quarter and half boundaries of each size at the same time. WRITE_CYCLES is 4 on both, so the busy window can be counted exactly, and strobes issued inside it can be shown to be ignored.

// File: rtl/sgPkg.sv
package sgPkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStatus;
    logic startCycle;
  } sgStrobes_t;

  // top two address bits against the protect code
  function automatic logic inProtRange(input logic [1:0] code, input logic [1:0] topBits);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return topBits == 2'b11;
      2'b10:   return topBits[1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/sgDatapath.sv
module sgDatapath
  import sgPkg::*;
#(
  parameter logic [1:0] INIT_BP   = 2'b00,
  parameter logic       INIT_WPEN = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  sgStrobes_t strobes,
  input  logic [7:0] loadData,
  input  logic [1:0] addrTop,
  input  logic       rdy,
  output logic       welQ,
  output logic       wpenQ,
  output logic       addrProtected,
  output logic [7:0] statusByte
);
  logic [1:0] bpQ = INIT_BP;
  logic       wpenReg = INIT_WPEN;
  logic       unusedData;

  assign unusedData = ^{loadData[6:4], loadData[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  welQ <= 1'b0;
    else if (strobes.clrWel)    welQ <= 1'b0;
    else if (strobes.setWel)    welQ <= 1'b1;
  end

  // non-volatile cells: no reset term
  always_ff @(posedge clk) begin
    if (strobes.loadStatus) begin
      wpenReg <= loadData[7];
      bpQ     <= loadData[3:2];
    end
  end

  assign wpenQ         = wpenReg;
  assign addrProtected = inProtRange(bpQ, addrTop);
  assign statusByte    = {wpenReg, 3'b000, bpQ, welQ, rdy};
endmodule

// File: rtl/sgControl.sv
module sgControl
  import sgPkg::*;
#(
  parameter int WRITE_CYCLES = 8,
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEnStb,
  input  logic       wrDisStb,
  input  logic       statWrStb,
  input  logic       arrWrStb,
  input  logic       wpN,
  input  logic       cycleBusy,
  input  logic       welQ,
  input  logic       wpenQ,
  input  logic       addrProtected,
  output sgStrobes_t strobes,
  output logic       rdy,
  output logic       statGrant,
  output logic       statReject,
  output logic       arrGrant,
  output logic       arrReject
);
  logic [CNT_W-1:0] cycleCnt;
  logic busy, live, selArr, selStat, selDis, selEn, hwLock, arrOk, statOk;

  assign busy    = (cycleCnt != '0) || cycleBusy;
  assign live    = !busy;
  assign selArr  = arrWrStb;
  assign selStat = statWrStb && !arrWrStb;
  assign selDis  = wrDisStb && !arrWrStb && !statWrStb;
  assign selEn   = wrEnStb && !arrWrStb && !statWrStb && !wrDisStb;

  assign hwLock = !wpN && wpenQ;
  assign arrOk  = welQ && !addrProtected;
  assign statOk = welQ && !hwLock;

  assign arrGrant   = live && selArr && arrOk;
  assign arrReject  = live && selArr && !arrOk;
  assign statGrant  = live && selStat && statOk;
  assign statReject = live && selStat && !statOk;

  always_comb begin
    strobes.startCycle = arrGrant || statGrant;
    strobes.loadStatus = statGrant;
    strobes.clrWel     = strobes.startCycle || (live && selDis);
    strobes.setWel     = live && selEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cycleCnt <= '0;
    else if (strobes.startCycle) cycleCnt <= CNT_W'(WRITE_CYCLES);
    else if (cycleCnt != '0)     cycleCnt <= cycleCnt - 1'b1;
  end

  assign rdy = busy;
endmodule

// File: rtl/statusWriteGuard.sv
module statusWriteGuard
  import sgPkg::*;
#(
  parameter int         ARRAY_KB     = 32,
  parameter int         WRITE_CYCLES = 8,
  parameter logic [1:0] INIT_BP      = 2'b00,
  parameter logic       INIT_WPEN    = 1'b0,
  localparam int        ADDR_W       = $clog2(ARRAY_KB * 1024)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEnStb,
  input  logic              wrDisStb,
  input  logic              statWrStb,
  input  logic [7:0]        statWrData,
  input  logic              arrWrStb,
  input  logic [ADDR_W-1:0] arrWrAddr,
  input  logic              wpN,
  input  logic              cycleBusy,
  output logic [7:0]        statusByte,
  output logic              statGrant,
  output logic              statReject,
  output logic              arrGrant,
  output logic              arrReject
);
  generate
    if (ARRAY_KB != 16 && ARRAY_KB != 32) begin : gBadSize
      $error("ARRAY_KB must be 16 or 32");
    end
  endgenerate

  sgStrobes_t strobes;
  logic welQ, wpenQ, addrProtected, rdy;
  logic unusedAddrLow;

  assign unusedAddrLow = ^arrWrAddr[ADDR_W-3:0];

  sgControl #(.WRITE_CYCLES(WRITE_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN),
    .wrEnStb(wrEnStb), .wrDisStb(wrDisStb), .statWrStb(statWrStb), .arrWrStb(arrWrStb),
    .wpN(wpN), .cycleBusy(cycleBusy),
    .welQ(welQ), .wpenQ(wpenQ), .addrProtected(addrProtected),
    .strobes(strobes), .rdy(rdy),
    .statGrant(statGrant), .statReject(statReject),
    .arrGrant(arrGrant), .arrReject(arrReject)
  );

  sgDatapath #(.INIT_BP(INIT_BP), .INIT_WPEN(INIT_WPEN)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .loadData(statWrData), .addrTop(arrWrAddr[ADDR_W-1 -: 2]), .rdy(rdy),
    .welQ(welQ), .wpenQ(wpenQ), .addrProtected(addrProtected),
    .statusByte(statusByte)
  );
endmodule

// File: rtl/statusWriteGuardChecker.sv
module statusWriteGuardChecker (
  input logic       clk,
  input logic       rstN,
  input logic       wpN,
  input logic       cycleBusy,
  input logic [7:0] statusByte,
  input logic       statGrant,
  input logic       statReject,
  input logic       arrGrant,
  input logic       arrReject
);
  assert_zero_bits_R1: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6:4] == 3'b000);

  assert_grant_needs_wel_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statGrant || arrGrant) |-> statusByte[1]);

  assert_full_protect_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[3:2] == 2'b11) |-> !arrGrant);

  assert_hw_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!wpN && statusByte[7]) |-> !statGrant);

  assert_after_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statGrant || arrGrant) |=> (statusByte[0] && !statusByte[1]));

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[0] |-> !(statGrant || statReject || arrGrant || arrReject));

  assert_busy_input_R8: assert property (@(posedge clk) disable iff (!rstN)
    cycleBusy |-> statusByte[0]);

  assert_nv_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !statGrant |=> $stable(statusByte[7:2]));

  assert_single_op_R10: assert property (@(posedge clk) disable iff (!rstN)
    !((statGrant || statReject) && (arrGrant || arrReject)));
endmodule

bind statusWriteGuard statusWriteGuardChecker chk (.*);

// File: tb/statusWriteGuard_test.sv
module statusWriteGuard_test;
  localparam int WC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEnStb = 0, wrDisStb = 0, statWrStb = 0, arrWrStb = 0, wpN = 1, cycleBusy = 0;
  logic [7:0] statWrData = '0;
  logic [14:0] arrWrAddr = '0;
  logic [7:0] stBig, stSmall;
  logic gsB, rsB, gaB, raB, gsS, rsS, gaS, raS;
  logic cgs, crs, cga, cra, cgaS, craS;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  statusWriteGuard #(.ARRAY_KB(32), .WRITE_CYCLES(WC), .INIT_BP(2'b10), .INIT_WPEN(1'b1)) uut (
    .clk(clk), .rstN(rstN), .wrEnStb(wrEnStb), .wrDisStb(wrDisStb),
    .statWrStb(statWrStb), .statWrData(statWrData), .arrWrStb(arrWrStb),
    .arrWrAddr(arrWrAddr), .wpN(wpN), .cycleBusy(cycleBusy), .statusByte(stBig),
    .statGrant(gsB), .statReject(rsB), .arrGrant(gaB), .arrReject(raB));

  statusWriteGuard #(.ARRAY_KB(16), .WRITE_CYCLES(WC)) uutSmall (
    .clk(clk), .rstN(rstN), .wrEnStb(wrEnStb), .wrDisStb(wrDisStb),
    .statWrStb(statWrStb), .statWrData(statWrData), .arrWrStb(arrWrStb),
    .arrWrAddr(arrWrAddr[13:0]), .wpN(wpN), .cycleBusy(cycleBusy), .statusByte(stSmall),
    .statGrant(gsS), .statReject(rsS), .arrGrant(gaS), .arrReject(raS));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic en, input logic dis, input logic sw, input logic aw,
                       input logic [7:0] d, input logic [14:0] a);
    @(negedge clk);
    wrEnStb = en; wrDisStb = dis; statWrStb = sw; arrWrStb = aw;
    statWrData = d; arrWrAddr = a;
    #1;
    cgs = gsB; crs = rsB; cga = gaB; cra = raB; cgaS = gaS; craS = raS;
    @(negedge clk);
    wrEnStb = 0; wrDisStb = 0; statWrStb = 0; arrWrStb = 0;
  endtask

  task automatic waitIdle();
    while (stBig[0] || stSmall[0]) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic setStatus(input logic [7:0] d);
    issue(1, 0, 0, 0, 8'h00, 15'h0);
    issue(0, 0, 1, 0, d, 15'h0);
    waitIdle();
  endtask

  function automatic logic prot(input logic [1:0] code, input int addr, input int size);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return addr >= (size * 3) / 4;
      2'b10:   return addr >= size / 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic testPowerOn_R9();
    check("R9 power-on big", stBig, 8'h88);
    check("R1 power-on small", stSmall, 8'h00);
  endtask

  task automatic testWel_R2();
    issue(1, 0, 0, 0, 8'h00, 15'h0);
    check("R2 set latch", stBig, 8'h8A);
    issue(0, 1, 0, 0, 8'h00, 15'h0);
    check("R2 clear latch", stBig, 8'h88);
    issue(1, 0, 0, 0, 8'h00, 15'h0);
    doReset();
    check("R2 reset clears latch", stBig[1], 1'b0);
  endtask

  task automatic testNoWel_R3();
    wpN = 1;
    issue(0, 0, 1, 0, 8'h00, 15'h0);
    check("R3 status reject", {cgs, crs}, 2'b01);
    check("R3 status unchanged", stBig, 8'h88);
    issue(0, 0, 0, 1, 8'h00, 15'h0000);
    check("R3 array reject", {cga, cra}, 2'b01);
  endtask

  task automatic testHwLock_R5_R7();
    int n = 0;
    wpN = 0;
    issue(1, 0, 0, 0, 8'h00, 15'h0);
    issue(0, 0, 1, 0, 8'h00, 15'h0);
    check("R5 locked status reject", {cgs, crs}, 2'b01);
    check("R5 status kept", stBig, 8'h8A);
    issue(0, 0, 0, 1, 8'h00, 15'h0100);
    check("R5 unprotected array grant", {cga, cra}, 2'b10);
    check("R7 latch cleared and busy", stBig[1:0], 2'b01);
    while (stBig[0]) begin n++; @(negedge clk); end
    check("R7 busy length", n, WC);
    wpN = 1;
    waitIdle();
  endtask

  task automatic testUnlock_R6_R1();
    wpN = 1;
    issue(1, 0, 0, 0, 8'h00, 15'h0);
    issue(0, 0, 1, 0, 8'hF5, 15'h0);
    check("R6 status grant", {cgs, crs}, 2'b10);
    check("R1 loaded byte big", stBig, 8'h85);
    check("R1 loaded byte small", stSmall, 8'h85);
    waitIdle();
    check("R6 idle after load", stBig, 8'h84);
  endtask

  task automatic testRanges_R4();
    logic [14:0] addrs [6] = '{15'h5FFF, 15'h6000, 15'h3FFF, 15'h4000, 15'h0000, 15'h7FFF};
    wpN = 1;
    for (int code = 0; code < 4; code++) begin
      setStatus({4'b0000, 2'(code), 2'b00});
      for (int i = 0; i < 6; i++) begin
        issue(1, 0, 0, 0, 8'h00, 15'h0);
        issue(0, 0, 0, 1, 8'h00, addrs[i]);
        check($sformatf("R4 big code %0d addr %0h", code, addrs[i]), {cga, cra},
              prot(2'(code), int'(addrs[i]), 32768) ? 2'b01 : 2'b10);
        check($sformatf("R4 small code %0d addr %0h", code, addrs[i][13:0]), {cgaS, craS},
              prot(2'(code), int'(addrs[i][13:0]), 16384) ? 2'b01 : 2'b10);
        waitIdle();
      end
    end
  endtask

  task automatic testBusy_R8();
    setStatus(8'h00);
    issue(1, 0, 0, 0, 8'h00, 15'h0);
    issue(0, 0, 0, 1, 8'h00, 15'h0010);
    issue(1, 0, 0, 0, 8'h00, 15'h0);
    check("R8 set ignored while busy", stBig[1], 1'b0);
    issue(0, 0, 1, 0, 8'h8C, 15'h0);
    check("R8 load ignored while busy", {cgs, crs}, 2'b00);
    waitIdle();
    check("R8 status unchanged", stBig, 8'h00);
    cycleBusy = 1;
    issue(1, 0, 0, 0, 8'h00, 15'h0);
    check("R8 external busy blocks set", stBig[1:0], 2'b01);
    issue(0, 0, 0, 1, 8'h00, 15'h0);
    check("R8 external busy no answer", {cga, cra}, 2'b00);
    cycleBusy = 0;
    @(negedge clk);
  endtask

  task automatic testPriority_R10();
    issue(1, 0, 0, 0, 8'h00, 15'h0);
    issue(1, 1, 0, 0, 8'h00, 15'h0);
    check("R10 clear beats set", stBig[1], 1'b0);
    issue(1, 0, 0, 0, 8'h00, 15'h0);
    issue(0, 0, 1, 1, 8'h0C, 15'h0020);
    check("R10 array beats status", {cga, cra, cgs, crs}, 4'b1000);
    check("R10 status not loaded", stBig[7:2], 6'h00);
    waitIdle();
  endtask

  task automatic testResetKeep_R9();
    setStatus(8'h8C);
    check("R9 loaded before reset", stBig, 8'h8C);
    doReset();
    check("R9 kept through reset", stBig, 8'h8C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testPowerOn_R9();
    testWel_R2();
    testNoWel_R3();
    testHwLock_R5_R7();
    testUnlock_R6_R1();
    testRanges_R4();
    testBusy_R8();
    testPriority_R10();
    testResetKeep_R9();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule